// File: doc/BRIEF.md
# Partitioned Event Counter Bank

A bank of event counters, one per event input, each 64 bits wide by default. A counter adds one on every clock cycle in which its event input is high and the counter is running. A runtime boundary value splits the bank into two groups. Counters whose index is below the boundary are the lower group. They obey a shared lower enable and a shared lower width-select. Counters at or above the boundary are the upper group. They obey their own upper enable and upper width-select inputs. A per-counter enable mask gates every counter in both groups.

Each counter has a sticky overflow flag. The width-select decides where that flag sets. In short mode it sets when the low part of the counter wraps, and the counter keeps counting into its upper bits. In long mode it sets only when the full width wraps. A single-cycle clear-all pulse zeroes every counter in both groups, whatever the width-select. It leaves the overflow flags untouched. Flags are cleared one by one through a write-one-to-clear mask.

Top module: `evb_bank`

## Requirements
- R1: A running counter whose event input is high in a cycle holds its previous value plus one after that clock edge. A counter that is not running, or has no event, keeps its value.
- R2: A counter with index below the boundary runs only when the lower enable is 1 and its mask bit is 1. With the lower enable at 0, every counter below the boundary is stopped.
- R3: A counter with index at or above the boundary runs only when the upper enable is 1 and its mask bit is 1. The lower enable has no effect on it.
- R4: When the boundary-valid input is 0, the boundary equals the number of counters. A boundary value above the number of counters is treated as the number of counters.
- R5: In short mode (width-select 0), an increment from a value whose low SHORT_W bits are all ones sets the flag. The counter still takes the full-width value plus one.
- R6: In long mode (width-select 1), an increment from all ones across the full width sets the flag, and the counter becomes 0. A wrap of the low SHORT_W bits alone does not set it.
- R7: Counters below the boundary take their width-select from the lower select input. Counters at or above it take theirs from the upper select input.
- R8: A clear-all pulse zeroes every counter after that edge, regardless of boundary, width-select or enables. An event in the same cycle is lost.
- R9: A clear-all pulse leaves every overflow flag unchanged.
- R10: A flag stays set until its bit in the flag-clear mask is 1. If a wrap and that clear bit fall in the same cycle, the flag ends up set.
- R11: While reset is held, all counters and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CTR | Event pulse per counter |
| cnt_en_i | input | NUM_CTR | Per-counter enable mask |
| lo_en_i | input | 1 | Enable for counters below the boundary |
| lo_long_i | input | 1 | Width-select for counters below the boundary (1 = full width) |
| hi_en_i | input | 1 | Enable for counters at or above the boundary |
| hi_long_i | input | 1 | Width-select for counters at or above the boundary |
| bnd_vld_i | input | 1 | 1 = use bnd_i as the boundary, 0 = boundary is NUM_CTR |
| bnd_i | input | BND_W | Partition boundary |
| clr_all_i | input | 1 | Single-cycle pulse that zeroes all counters |
| ovf_clr_i | input | NUM_CTR | Write-one-to-clear mask for the overflow flags |
| cnt_o | output | NUM_CTR*CTR_W | Counter values, counter i at bits [i*CTR_W +: CTR_W] |
| ovf_o | output | NUM_CTR | Sticky overflow flags |

## Verification
Two collisions are provoked on purpose, because either one can lose information. The first is a clear-all pulse in a cycle where events are high: every counter must read zero afterwards while all flags keep their values. The second is a flag-clear bit in the very cycle its counter wraps: the flag must read set afterwards, and a later clear with no wrap must drop it. Random traffic with rare clear-all and flag-clear pulses makes both collisions happen again many times. A bench model written from the requirements judges every counter and flag on every cycle.

// File: rtl/evb_pkg.sv
package evb_pkg;

    // Group a counter belongs to, decided by the runtime boundary
    typedef enum logic {
        GRP_LOW  = 1'b0,
        GRP_HIGH = 1'b1
    } grp_e;

endpackage

// File: rtl/evb_part_ctl.sv
module evb_part_ctl
    import evb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int BND_W   = $clog2(NUM_CTR + 1)
) (
    input  logic [NUM_CTR-1:0] cnt_en_i,
    input  logic               lo_en_i,
    input  logic               lo_long_i,
    input  logic               hi_en_i,
    input  logic               hi_long_i,
    input  logic               bnd_vld_i,
    input  logic [BND_W-1:0]   bnd_i,
    output logic [NUM_CTR-1:0] run_o,
    output logic [NUM_CTR-1:0] long_o
);

    localparam logic [BND_W-1:0] FULL_BND = BND_W'(NUM_CTR);

    logic [BND_W-1:0] bnd_eff;
    grp_e             grp [NUM_CTR];

    // Effective boundary: absent or oversize values mean "all counters low"
    always_comb begin
        if (!bnd_vld_i || (bnd_i > FULL_BND)) begin
            bnd_eff = FULL_BND;
        end else begin
            bnd_eff = bnd_i;
        end
    end

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_sel
        always_comb begin
            grp[gi]    = (BND_W'(gi) < bnd_eff) ? GRP_LOW : GRP_HIGH;
            long_o[gi] = (grp[gi] == GRP_LOW) ? lo_long_i : hi_long_i;
            run_o[gi]  = cnt_en_i[gi] & ((grp[gi] == GRP_LOW) ? lo_en_i : hi_en_i);
        end
    end

endmodule

// File: rtl/evb_slot.sv
module evb_slot #(
    parameter int CTR_W   = 64,
    parameter int SHORT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             long_i,
    input  logic             evt_i,
    input  logic             clr_all_i,
    input  logic             ovf_clr_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
        logic             ovf;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  wrap;
    logic  full_ones;
    logic  low_ones;

    always_comb begin
        full_ones = &slot_q.cnt;
        low_ones  = &slot_q.cnt[SHORT_W-1:0];
        slot_d    = slot_q;
        wrap      = 1'b0;
        if (clr_all_i) begin
            slot_d.cnt = '0;
        end else if (run_i && evt_i) begin
            slot_d.cnt = slot_q.cnt + CTR_W'(1);
            wrap       = long_i ? full_ones : low_ones;
        end
        slot_d.ovf = (slot_q.ovf & ~ovf_clr_i) | wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign cnt_o = slot_q.cnt;
    assign ovf_o = slot_q.ovf;

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && evt_i && !clr_all_i) |=> (cnt_o == $past(cnt_o) + CTR_W'(1)));

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_i && evt_i) && !clr_all_i) |=> $stable(cnt_o));

    assert_long_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && evt_i && !clr_all_i && long_i && full_ones) |=> (cnt_o == '0 && ovf_o));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (cnt_o == '0));

    assert_clear_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_i && !ovf_clr_i) |=> (ovf_o == $past(ovf_o)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

endmodule

// File: rtl/evb_bank.sv
module evb_bank #(
    parameter int NUM_CTR  = 4,
    parameter int CTR_W    = 64,
    parameter int SHORT_W  = 32,
    localparam int BND_W   = $clog2(NUM_CTR + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CTR-1:0]         evt_i,
    input  logic [NUM_CTR-1:0]         cnt_en_i,
    input  logic                       lo_en_i,
    input  logic                       lo_long_i,
    input  logic                       hi_en_i,
    input  logic                       hi_long_i,
    input  logic                       bnd_vld_i,
    input  logic [BND_W-1:0]           bnd_i,
    input  logic                       clr_all_i,
    input  logic [NUM_CTR-1:0]         ovf_clr_i,
    output logic [NUM_CTR*CTR_W-1:0]   cnt_o,
    output logic [NUM_CTR-1:0]         ovf_o
);

    logic [NUM_CTR-1:0] run;
    logic [NUM_CTR-1:0] long_sel;

    evb_part_ctl #(
        .NUM_CTR (NUM_CTR),
        .BND_W   (BND_W)
    ) u_ctl (
        .cnt_en_i  (cnt_en_i),
        .lo_en_i   (lo_en_i),
        .lo_long_i (lo_long_i),
        .hi_en_i   (hi_en_i),
        .hi_long_i (hi_long_i),
        .bnd_vld_i (bnd_vld_i),
        .bnd_i     (bnd_i),
        .run_o     (run),
        .long_o    (long_sel)
    );

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_slot
        evb_slot #(
            .CTR_W   (CTR_W),
            .SHORT_W (SHORT_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run[gi]),
            .long_i    (long_sel[gi]),
            .evt_i     (evt_i[gi]),
            .clr_all_i (clr_all_i),
            .ovf_clr_i (ovf_clr_i[gi]),
            .cnt_o     (cnt_o[gi*CTR_W +: CTR_W]),
            .ovf_o     (ovf_o[gi])
        );
    end

    // Both enables low: nothing in either group may move
    assert_all_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_en_i && !hi_en_i && !clr_all_i) |=> $stable(cnt_o));

    // No boundary given: the whole bank is the lower group, so the lower enable stops all
    assert_no_bnd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bnd_vld_i && !lo_en_i && !clr_all_i) |=> $stable(cnt_o));

    // Empty mask: no counter moves whatever the group controls say
    assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_en_i == '0) && !clr_all_i) |=> $stable(cnt_o));

endmodule

// File: tb/evb_bank_tb.sv
module evb_bank_tb;

    localparam int N       = 4;
    localparam int CTR_W   = 12;
    localparam int SHORT_W = 6;
    localparam int BND_W   = $clog2(N + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         evt = '0;
    logic [N-1:0]         cnt_en = '0;
    logic                 lo_en = 1'b0;
    logic                 lo_long = 1'b0;
    logic                 hi_en = 1'b0;
    logic                 hi_long = 1'b0;
    logic                 bnd_vld = 1'b0;
    logic [BND_W-1:0]     bnd = '0;
    logic                 clr_all = 1'b0;
    logic [N-1:0]         ovf_clr = '0;
    logic [N*CTR_W-1:0]   cnt_flat;
    logic [N-1:0]         ovf;

    int n_chk  = 0;
    int n_fail = 0;

    logic [CTR_W-1:0] m_cnt [N];
    logic             m_ovf [N];

    always #4 clk = ~clk;  // 125 MHz

    evb_bank #(.NUM_CTR(N), .CTR_W(CTR_W), .SHORT_W(SHORT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .cnt_en_i  (cnt_en),
        .lo_en_i   (lo_en),
        .lo_long_i (lo_long),
        .hi_en_i   (hi_en),
        .hi_long_i (hi_long),
        .bnd_vld_i (bnd_vld),
        .bnd_i     (bnd),
        .clr_all_i (clr_all),
        .ovf_clr_i (ovf_clr),
        .cnt_o     (cnt_flat),
        .ovf_o     (ovf)
    );

    function automatic logic [CTR_W-1:0] dut_cnt(int i);
        return cnt_flat[i*CTR_W +: CTR_W];
    endfunction

    // Boundary per R4
    function automatic int eff_bnd();
        if (!bnd_vld) return N;
        if (int'(bnd) > N) return N;
        return int'(bnd);
    endfunction

    task automatic chk_cnt(string tag, int i, logic [CTR_W-1:0] exp);
        n_chk++;
        if (dut_cnt(i) !== exp) begin
            n_fail++;
            $display("FAIL %s counter %0d value: actual %0d expected %0d", tag, i, dut_cnt(i), exp);
        end
    endtask

    task automatic chk_ovf(string tag, int i, logic exp);
        n_chk++;
        if (ovf[i] !== exp) begin
            n_fail++;
            $display("FAIL %s counter %0d flag: actual %0b expected %0b", tag, i, ovf[i], exp);
        end
    endtask

    // One clock: model follows R1..R10 at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            logic low_grp;
            logic run;
            logic lng;
            logic wrap;
            low_grp = (i < eff_bnd());
            run  = cnt_en[i] && (low_grp ? lo_en : hi_en);
            lng  = low_grp ? lo_long : hi_long;
            wrap = 1'b0;
            if (clr_all) begin
                m_cnt[i] = '0;
            end else if (run && evt[i]) begin
                wrap = lng ? (m_cnt[i] == {CTR_W{1'b1}})
                           : (m_cnt[i][SHORT_W-1:0] == {SHORT_W{1'b1}});
                m_cnt[i] = m_cnt[i] + 1'b1;
            end
            m_ovf[i] = (m_ovf[i] && !ovf_clr[i]) || wrap;
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk_cnt("R1 model", i, m_cnt[i]);
            chk_ovf("R10 model", i, m_ovf[i]);
        end
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = '0;
            m_ovf[i] = 1'b0;
        end
        // R11: reset state
        repeat (3) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            chk_cnt("R11", i, '0);
            chk_ovf("R11", i, 1'b0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: boundary 2, lower group enabled, upper disabled
        bnd_vld = 1'b1; bnd = 3'd2; lo_en = 1'b1; hi_en = 1'b0;
        cnt_en = 4'b0101; evt = 4'b1111;
        ticks(10);
        chk_cnt("R2", 0, 12'd10);
        chk_cnt("R2", 1, 12'd0);
        chk_cnt("R3", 2, 12'd0);
        chk_cnt("R3", 3, 12'd0);

        // R2/R3: lower enable off, upper on
        lo_en = 1'b0; hi_en = 1'b1; cnt_en = 4'b1111;
        ticks(5);
        chk_cnt("R2", 0, 12'd10);
        chk_cnt("R2", 1, 12'd0);
        chk_cnt("R3", 2, 12'd5);
        chk_cnt("R3", 3, 12'd5);

        // R4: no boundary -> all lower, upper enable irrelevant
        bnd_vld = 1'b0; bnd = '0;
        ticks(3);
        chk_cnt("R4", 2, 12'd5);
        chk_cnt("R4", 3, 12'd5);
        // R4: oversize boundary clamps
        bnd_vld = 1'b1; bnd = 3'd7;
        ticks(3);
        chk_cnt("R4", 3, 12'd5);
        lo_en = 1'b1;
        ticks(2);
        chk_cnt("R4", 0, 12'd12);
        chk_cnt("R4", 1, 12'd2);
        chk_cnt("R4", 2, 12'd7);

        // R8: clear-all together with events
        clr_all = 1'b1;
        tick();
        clr_all = 1'b0;
        for (int i = 0; i < N; i++) chk_cnt("R8", i, '0);

        // R5: short wrap on counter 0
        bnd = 3'd4; lo_long = 1'b0; cnt_en = 4'b0001; evt = 4'b0001;
        ticks(63);
        chk_cnt("R5", 0, 12'd63);
        chk_ovf("R5", 0, 1'b0);
        tick();
        chk_cnt("R5", 0, 12'd64);
        chk_ovf("R5", 0, 1'b1);

        // R9: clear-all keeps flag
        evt = '0; clr_all = 1'b1;
        tick();
        clr_all = 1'b0;
        chk_cnt("R9", 0, '0);
        chk_ovf("R9", 0, 1'b1);

        // R10: clear coinciding with wrap keeps flag set
        evt = 4'b0001;
        ticks(63);
        ovf_clr = 4'b0001;
        tick();
        chk_ovf("R10", 0, 1'b1);
        chk_cnt("R10", 0, 12'd64);
        evt = '0;
        tick();
        ovf_clr = '0;
        chk_ovf("R10", 0, 1'b0);
        ticks(2);
        chk_ovf("R10", 0, 1'b0);

        // R6/R7: all upper, upper select long, lower select short
        clr_all = 1'b1;
        tick();
        clr_all = 1'b0;
        bnd = 3'd0; lo_long = 1'b0; hi_long = 1'b1; hi_en = 1'b1; lo_en = 1'b0;
        cnt_en = 4'b0010; evt = 4'b0010;
        ticks(64);
        chk_cnt("R7", 1, 12'd64);
        chk_ovf("R7", 1, 1'b0);
        ticks(4031);
        chk_cnt("R6", 1, 12'd4095);
        chk_ovf("R6", 1, 1'b0);
        tick();
        chk_cnt("R6", 1, 12'd0);
        chk_ovf("R6", 1, 1'b1);

        // Random mix: collisions of clear-all with events and flag clears with wraps
        for (int k = 0; k < 3000; k++) begin
            evt     = N'($urandom);
            cnt_en  = N'($urandom | $urandom);
            lo_en   = ($urandom % 4) != 0;
            hi_en   = ($urandom % 4) != 0;
            lo_long = ($urandom % 8) == 0;
            hi_long = ($urandom % 8) == 0;
            bnd_vld = ($urandom % 8) != 0;
            bnd     = BND_W'($urandom);
            clr_all = ($urandom % 64) == 0;
            ovf_clr = (($urandom % 16) == 0) ? N'($urandom) : '0;
            tick();
        end

        report();
    end

endmodule